// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data side of a small 16-bit processor core. Every transfer between its storage elements travels over one shared bus. Four sources can place a value on that bus: the ALU, the address adder, the memory data register and the program counter. An external sequencer sets, in each cycle, which source drives the bus and which registers capture it. The sequencer also sets the multiplexer selects and the ALU operation. The block owns the eight-entry register file, the ALU, the N/Z/P condition flags, the program counter with its next-value multiplexer, the memory address register with its input multiplexer, the memory data register and the instruction register.

The bus is built as a gated AND-OR multiplexer. A small control module checks the drive selects and turns the external strobes into a strobe bundle for the datapath. If the sequencer asserts more than one drive select, the bus reads zero and an error output goes high. The memory array, the device registers and the instruction sequencer sit outside the block.

Top module: `shared_bus_datapath`

## Requirements
- R1: `driveSel` is one-hot, with bit 0 for the ALU, bit 1 for the address adder, bit 2 for the MDR and bit 3 for the PC. With exactly one bit set, `busValue` equals that source in the same cycle. With no bit set, `busValue` is 0 and `busConflict` is 0.
- R2: With two or more bits of `driveSel` set, `busConflict` is 1 and `busValue` is 0 in that cycle.
- R3: The register file has eight 16-bit entries. On a clock edge with `ldReg` high, the entry at `dstAddr` takes `busValue`. `rdA` and `rdB` show the entries at `srcAAddr` and `srcBAddr` without delay.
- R4: A register whose load enable is low keeps its value across the clock edge. This holds for each register-file entry, PC, MAR, MDR, IR and the flags.
- R5: The ALU takes A = `rdA`. B is `rdB` when `immSel` is 0, and the sign-extended IR[4:0] when `immSel` is 1. The `aluOp` values are 0 for A+B, 1 for A AND B, 2 for NOT A and 3 for A passed through.
- R6: On an edge with `ldCc` high, the flags take N = bus[15] and Z = (bus == 0). P is set otherwise. Exactly one flag is set at all times.
- R7: On an edge with `ldPc` high, PC takes a value chosen by `pcSel`: 0 gives PC+1, 1 gives the address adder, 2 gives `busValue` and 3 keeps PC.
- R8: The address adder output is the base plus the sign-extended IR[8:0]. The base is PC when `baseSel` is 0 and `rdA` when `baseSel` is 1.
- R9: On an edge with `ldMar` high, MAR takes the zero-extended IR[7:0] when `marSel` is 0, and the address adder output when `marSel` is 1.
- R10: On an edge with `ldMdr` high, MDR takes `memRdata`. On an edge with `ldIr` high, IR takes `busValue`.
- R11: After reset, PC, MAR, MDR, IR and all register-file entries are 0, and the flags are N=0, Z=1, P=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| driveSel | input | 4 | One-hot bus drive select (ALU, adder, MDR, PC) |
| ldReg | input | 1 | Register-file write enable |
| ldCc | input | 1 | Condition-flag load enable |
| ldPc | input | 1 | PC load enable |
| ldMar | input | 1 | MAR load enable |
| ldMdr | input | 1 | MDR load enable |
| ldIr | input | 1 | IR load enable |
| pcSel | input | 2 | PC next-value select |
| marSel | input | 1 | MAR input select |
| baseSel | input | 1 | Address adder base select |
| immSel | input | 1 | ALU operand B select |
| aluOp | input | 2 | ALU operation |
| dstAddr | input | 3 | Register-file write address |
| srcAAddr | input | 3 | Register-file read address A |
| srcBAddr | input | 3 | Register-file read address B |
| memRdata | input | 16 | Data from memory into MDR |
| busValue | output | 16 | Current bus value |
| busConflict | output | 1 | More than one drive select asserted |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagP | output | 1 | Positive flag |
| pcOut | output | 16 | Program counter |
| marOut | output | 16 | Memory address register |
| irOut | output | 16 | Instruction register |
| rdA | output | 16 | Register-file read port A |
| rdB | output | 16 | Register-file read port B |

## Verification
The bench builds the block with its default parameters: a 16-bit word, eight registers, a 5-bit immediate and a 9-bit address offset. At these values, random register contents drive bit 15 often enough that negative, zero and positive bus values all occur. IR fields loaded from memory data exercise both signs of each sign extension. Random drive patterns include empty and multi-bit selects, so the conflict path is exercised many times besides the directed cases.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int SRC_COUNT = 4;
  localparam int SRC_ALU   = 0;
  localparam int SRC_ADR   = 1;
  localparam int SRC_MDR   = 2;
  localparam int SRC_PC    = 3;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_AND  = 2'd1,
    ALU_NOT  = 2'd2,
    ALU_PASS = 2'd3
  } aluOpE;

  typedef enum logic [1:0] {
    PC_INC  = 2'd0,
    PC_ADR  = 2'd1,
    PC_BUS  = 2'd2,
    PC_KEEP = 2'd3
  } pcSelE;

  typedef struct packed {
    logic [SRC_COUNT-1:0] drive;
    logic                 conflict;
    logic                 wrReg;
    logic                 wrCc;
    logic                 wrPc;
    logic                 wrMar;
    logic                 wrMdr;
    logic                 wrIr;
  } strobeT;
endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 8,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddrA,
  input  logic [AW-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  logic [DATA_W-1:0] regQ [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[g] <= '0;
      else if (wrEn && (wrAddr == AW'(g)))
        regQ[g] <= wrData;
    end
  end

  assign rdDataA = regQ[rdAddrA];
  assign rdDataB = regQ[rdAddrB];
endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluOpE             op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      ALU_ADD:  result = opA + opB;
      ALU_AND:  result = opA & opB;
      ALU_NOT:  result = ~opA;
      ALU_PASS: result = opA;
      default:  result = opA;
    endcase
  end
endmodule

// File: rtl/sbd_ctrl.sv
module sbd_ctrl
  import sbd_pkg::*;
(
  input  logic [SRC_COUNT-1:0] driveSel,
  input  logic                 ldReg,
  input  logic                 ldCc,
  input  logic                 ldPc,
  input  logic                 ldMar,
  input  logic                 ldMdr,
  input  logic                 ldIr,
  output strobeT               strobe
);
  localparam int CW = $clog2(SRC_COUNT + 1);

  logic [CW-1:0] activeCount;
  logic          multiDrive;

  always_comb begin
    activeCount = '0;
    for (int i = 0; i < SRC_COUNT; i++)
      activeCount = activeCount + CW'(driveSel[i]);
  end

  assign multiDrive = (activeCount > CW'(1));

  always_comb begin
    strobe.drive    = multiDrive ? '0 : driveSel;
    strobe.conflict = multiDrive;
    strobe.wrReg    = ldReg;
    strobe.wrCc     = ldCc;
    strobe.wrPc     = ldPc;
    strobe.wrMar    = ldMar;
    strobe.wrMdr    = ldMdr;
    strobe.wrIr     = ldIr;
  end
endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
  import sbd_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int REG_COUNT = 8,
  parameter int IMM_W     = 5,
  parameter int OFF_W     = 9,
  parameter int VEC_W     = 8,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  pcSelE             pcSel,
  input  logic              marSel,
  input  logic              baseSel,
  input  logic              immSel,
  input  aluOpE             aluOp,
  input  logic [AW-1:0]     dstAddr,
  input  logic [AW-1:0]     srcAAddr,
  input  logic [AW-1:0]     srcBAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] busValue,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagP,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] marOut,
  output logic [DATA_W-1:0] irOut,
  output logic [DATA_W-1:0] rdA,
  output logic [DATA_W-1:0] rdB
);
  logic [DATA_W-1:0] pcQ, marQ, mdrQ, irQ;
  logic              nQ, zQ, pQ;
  logic [DATA_W-1:0] immExt, offExt, vecExt;
  logic [DATA_W-1:0] aluB, aluOut, adrBase, adrOut;
  logic [DATA_W-1:0] pcNext, marNext;
  logic [DATA_W-1:0] srcVal   [SRC_COUNT];
  logic [DATA_W-1:0] srcGated [SRC_COUNT];

  sbd_regfile #(.DATA_W(DATA_W), .REG_COUNT(REG_COUNT)) uRegs (
    .clk(clk), .rstN(rstN),
    .wrEn(strobe.wrReg), .wrAddr(dstAddr), .wrData(busValue),
    .rdAddrA(srcAAddr), .rdAddrB(srcBAddr),
    .rdDataA(rdA), .rdDataB(rdB)
  );

  assign immExt = {{(DATA_W-IMM_W){irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign offExt = {{(DATA_W-OFF_W){irQ[OFF_W-1]}}, irQ[OFF_W-1:0]};
  assign vecExt = {{(DATA_W-VEC_W){1'b0}}, irQ[VEC_W-1:0]};

  assign aluB = immSel ? immExt : rdB;

  sbd_alu #(.DATA_W(DATA_W)) uAlu (
    .op(aluOp), .opA(rdA), .opB(aluB), .result(aluOut)
  );

  assign adrBase = baseSel ? rdA : pcQ;
  assign adrOut  = adrBase + offExt;

  // Bus as gated AND-OR: ctrl guarantees at most one drive strobe
  always_comb begin
    srcVal[SRC_ALU] = aluOut;
    srcVal[SRC_ADR] = adrOut;
    srcVal[SRC_MDR] = mdrQ;
    srcVal[SRC_PC]  = pcQ;
  end

  for (genvar s = 0; s < SRC_COUNT; s++) begin : gDrive
    assign srcGated[s] = strobe.drive[s] ? srcVal[s] : '0;
  end

  always_comb begin
    busValue = '0;
    for (int s = 0; s < SRC_COUNT; s++)
      busValue = busValue | srcGated[s];
  end

  always_comb begin
    unique case (pcSel)
      PC_INC:  pcNext = pcQ + DATA_W'(1);
      PC_ADR:  pcNext = adrOut;
      PC_BUS:  pcNext = busValue;
      PC_KEEP: pcNext = pcQ;
      default: pcNext = pcQ;
    endcase
  end

  assign marNext = marSel ? adrOut : vecExt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= '0;
      marQ <= '0;
      mdrQ <= '0;
      irQ  <= '0;
      nQ   <= 1'b0;
      zQ   <= 1'b1;
      pQ   <= 1'b0;
    end else begin
      if (strobe.wrPc)  pcQ  <= pcNext;
      if (strobe.wrMar) marQ <= marNext;
      if (strobe.wrMdr) mdrQ <= memRdata;
      if (strobe.wrIr)  irQ  <= busValue;
      if (strobe.wrCc) begin
        nQ <= busValue[DATA_W-1];
        zQ <= (busValue == '0);
        pQ <= !busValue[DATA_W-1] && (busValue != '0);
      end
    end
  end

  assign pcOut  = pcQ;
  assign marOut = marQ;
  assign irOut  = irQ;
  assign flagN  = nQ;
  assign flagZ  = zQ;
  assign flagP  = pQ;
endmodule

// File: rtl/shared_bus_datapath.sv
module shared_bus_datapath
  import sbd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  driveSel,
  input  logic        ldReg,
  input  logic        ldCc,
  input  logic        ldPc,
  input  logic        ldMar,
  input  logic        ldMdr,
  input  logic        ldIr,
  input  logic [1:0]  pcSel,
  input  logic        marSel,
  input  logic        baseSel,
  input  logic        immSel,
  input  logic [1:0]  aluOp,
  input  logic [2:0]  dstAddr,
  input  logic [2:0]  srcAAddr,
  input  logic [2:0]  srcBAddr,
  input  logic [15:0] memRdata,
  output logic [15:0] busValue,
  output logic        busConflict,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagP,
  output logic [15:0] pcOut,
  output logic [15:0] marOut,
  output logic [15:0] irOut,
  output logic [15:0] rdA,
  output logic [15:0] rdB
);
  strobeT strobe;

  sbd_ctrl uCtrl (
    .driveSel(driveSel), .ldReg(ldReg), .ldCc(ldCc), .ldPc(ldPc),
    .ldMar(ldMar), .ldMdr(ldMdr), .ldIr(ldIr), .strobe(strobe)
  );

  sbd_datapath #(
    .DATA_W(16), .REG_COUNT(8), .IMM_W(5), .OFF_W(9), .VEC_W(8)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcSel(pcSelE'(pcSel)), .marSel(marSel), .baseSel(baseSel),
    .immSel(immSel), .aluOp(aluOpE'(aluOp)),
    .dstAddr(dstAddr), .srcAAddr(srcAAddr), .srcBAddr(srcBAddr),
    .memRdata(memRdata), .busValue(busValue),
    .flagN(flagN), .flagZ(flagZ), .flagP(flagP),
    .pcOut(pcOut), .marOut(marOut), .irOut(irOut),
    .rdA(rdA), .rdB(rdB)
  );

  assign busConflict = strobe.conflict;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  driveSel,
  input logic        ldCc,
  input logic        ldPc,
  input logic [1:0]  pcSel,
  input logic        ldMar,
  input logic        marSel,
  input logic [15:0] busValue,
  input logic        busConflict,
  input logic        flagN,
  input logic        flagZ,
  input logic        flagP,
  input logic [15:0] pcOut,
  input logic [15:0] marOut,
  input logic [15:0] irOut
);
  AST_NO_CONFLICT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(driveSel) |-> !busConflict); // R1

  AST_CONFLICT_ZERO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(driveSel) > 1) |-> (busConflict && busValue == 16'h0000)); // R2

  AST_FLAGS_EXACTLY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagN, flagZ, flagP}) == 1); // R6

  AST_FLAGS_ZERO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ldCc && busValue == 16'h0000) |=> flagZ); // R6

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ldCc |=> $stable({flagN, flagZ, flagP})); // R4

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ldPc |=> $stable(pcOut)); // R4

  AST_PC_INCREMENT: assert property (@(posedge clk) disable iff (!rstN)
    (ldPc && pcSel == 2'd0) |=> pcOut == $past(pcOut) + 16'd1); // R7

  AST_MAR_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    (ldMar && !marSel) |=> marOut == {8'h00, $past(irOut[7:0])}); // R9
endmodule

bind shared_bus_datapath sbd_checker uChk (
  .clk(clk), .rstN(rstN), .driveSel(driveSel), .ldCc(ldCc), .ldPc(ldPc),
  .pcSel(pcSel), .ldMar(ldMar), .marSel(marSel), .busValue(busValue),
  .busConflict(busConflict), .flagN(flagN), .flagZ(flagZ), .flagP(flagP),
  .pcOut(pcOut), .marOut(marOut), .irOut(irOut)
);

// File: tb/shared_bus_datapath_test.sv
`timescale 1ns/1ps
module shared_bus_datapath_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  driveSel = '0;
  logic        ldReg = 0, ldCc = 0, ldPc = 0, ldMar = 0, ldMdr = 0, ldIr = 0;
  logic [1:0]  pcSel = '0;
  logic        marSel = 0, baseSel = 0, immSel = 0;
  logic [1:0]  aluOp = '0;
  logic [2:0]  dstAddr = '0, srcAAddr = '0, srcBAddr = '0;
  logic [15:0] memRdata = '0;
  logic [15:0] busValue, pcOut, marOut, irOut, rdA, rdB;
  logic        busConflict, flagN, flagZ, flagP;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  // Bench model state
  logic [15:0] mRegs [8];
  logic [15:0] mPc, mMar, mMdr, mIr;
  logic [2:0]  mFlags;

  shared_bus_datapath uut (.*);

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] sx(input logic [15:0] v, input int w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = (i < w) ? v[i] : v[w-1];
    return r;
  endfunction

  function automatic logic [15:0] expAlu();
    logic [15:0] a, b;
    a = mRegs[srcAAddr];
    b = immSel ? sx(mIr, 5) : mRegs[srcBAddr];
    case (aluOp)
      2'd0: return a + b;
      2'd1: return a & b;
      2'd2: return ~a;
      default: return a;
    endcase
  endfunction

  function automatic logic [15:0] expAdr();
    return (baseSel ? mRegs[srcAAddr] : mPc) + sx(mIr, 9);
  endfunction

  function automatic logic [15:0] expBus();
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(driveSel[i]);
    if (n != 1) return 16'h0000;
    case (driveSel)
      4'b0001: return expAlu();
      4'b0010: return expAdr();
      4'b0100: return mMdr;
      default: return mPc;
    endcase
  endfunction

  function automatic string busTag();
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(driveSel[i]);
    if (n > 1) return "R2";
    if (driveSel == 4'b0001) return "R5";
    if (driveSel == 4'b0010) return "R8";
    if (driveSel == 4'b0100) return "R10";
    return "R1";
  endfunction

  // One cycle: inputs are already driven; check combinational, clock, check state
  task automatic step();
    logic [15:0] bus, nPc;
    int n = 0;
    #1;
    for (int i = 0; i < 4; i++) n += int'(driveSel[i]);
    bus = expBus();
    chk(busTag(), busValue, bus);
    chk("R2", {15'd0, busConflict}, {15'd0, n > 1});
    chk("R3", rdA, mRegs[srcAAddr]);
    chk("R3", rdB, mRegs[srcBAddr]);
    case (pcSel)
      2'd0: nPc = mPc + 16'd1;
      2'd1: nPc = expAdr();
      2'd2: nPc = bus;
      default: nPc = mPc;
    endcase
    if (ldMar) mMar = marSel ? expAdr() : {8'h00, mIr[7:0]};
    if (ldPc)  mPc  = nPc;
    if (ldMdr) mMdr = memRdata;
    if (ldIr)  mIr  = bus;
    if (ldReg) mRegs[dstAddr] = bus;
    if (ldCc)  mFlags = bus[15] ? 3'b100 : (bus == 16'h0000 ? 3'b010 : 3'b001);
    @(posedge clk);
    #1;
    chk(ldPc ? "R7" : "R4", pcOut, mPc);
    chk(ldMar ? "R9" : "R4", marOut, mMar);
    chk(ldIr ? "R10" : "R4", irOut, mIr);
    chk(ldCc ? "R6" : "R4", {13'd0, flagN, flagZ, flagP}, {13'd0, mFlags});
    @(negedge clk);
  endtask

  task automatic idle();
    driveSel = '0; ldReg = 0; ldCc = 0; ldPc = 0; ldMar = 0; ldMdr = 0; ldIr = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mRegs[i] = '0;
    mPc = '0; mMar = '0; mMdr = '0; mIr = '0; mFlags = 3'b010;
    repeat (3) @(negedge clk);
    #1;
    chk("R11", pcOut, 16'h0000);
    chk("R11", marOut, 16'h0000);
    chk("R11", irOut, 16'h0000);
    chk("R11", {13'd0, flagN, flagZ, flagP}, 16'h0002);
    chk("R11", rdA, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);

    // Directed: memory word into MDR, then MDR onto bus into IR and flags (negative)
    idle(); memRdata = 16'h81F3; ldMdr = 1; step();
    idle(); driveSel = 4'b0100; ldIr = 1; ldCc = 1; ldReg = 1; dstAddr = 3'd5; step();
    // Directed: zero result from ALU AND with immediate (IR[4:0]=10011)
    idle(); driveSel = 4'b0001; aluOp = 2'd1; srcAAddr = 3'd0; immSel = 1; ldCc = 1; step();
    // Directed: NOT of a register, positive check on PASS
    idle(); driveSel = 4'b0001; aluOp = 2'd2; srcAAddr = 3'd5; ldCc = 1; ldReg = 1; dstAddr = 3'd1; step();
    idle(); driveSel = 4'b0001; aluOp = 2'd3; srcAAddr = 3'd1; ldCc = 1; step();
    // Directed: PC increment, adder into PC and MAR, trap vector into MAR
    idle(); ldPc = 1; pcSel = 2'd0; step();
    idle(); ldPc = 1; pcSel = 2'd1; baseSel = 0; ldMar = 1; marSel = 1; step();
    idle(); ldMar = 1; marSel = 0; ldPc = 1; pcSel = 2'd3; step();
    // Directed: conflicts, bus must read zero and load zero
    idle(); driveSel = 4'b1100; ldReg = 1; dstAddr = 3'd5; ldCc = 1; ldPc = 1; pcSel = 2'd2; step();
    idle(); driveSel = 4'b1111; ldIr = 1; step();
    // Directed: empty select
    idle(); ldCc = 1; ldReg = 1; dstAddr = 3'd2; step();

    for (int k = 0; k < 3000; k++) begin
      int r = int'($urandom % 16);
      if (r < 10)      driveSel = 4'b0001 << (r % 4);
      else if (r < 12) driveSel = 4'b0000;
      else             driveSel = 4'($urandom);
      ldReg = 1'($urandom); ldCc = 1'($urandom); ldPc = 1'($urandom);
      ldMar = 1'($urandom); ldMdr = 1'($urandom); ldIr = 1'($urandom);
      pcSel = 2'($urandom); marSel = 1'($urandom); baseSel = 1'($urandom);
      immSel = 1'($urandom); aluOp = 2'($urandom);
      dstAddr = 3'($urandom); srcAAddr = 3'($urandom); srcBAddr = 3'($urandom);
      memRdata = (r == 3) ? 16'h0000 : 16'($urandom);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    finished = 1;
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule